// File: doc/BRIEF.md
# Program Counter and Stack Sequencer

This block owns the 15-bit program counter and the 8-bit data-memory stack pointer of a small byte-oriented processor. A decoder presents one control-flow or stack operation at a time on `op_code` with `op_start`. The block then updates the program counter for jumps, computes call targets, and pushes or pops bytes through a single byte-wide data-memory port. The stack grows toward lower addresses. A program counter pushed to the stack is split into a low byte and a high byte, and the high byte's top bit is zero.

Jumps, relative branches and no-operation complete at the clock edge that accepts them. Stack operations run a short sequence with one memory access per cycle, and `busy` is high while the sequence runs. Memory read data is expected on `mem_rdata` one cycle after `mem_re`. Return-from-interrupt also turns on the global interrupt enable. A pop delivers the byte it read on `acc_out`, together with a one-cycle `acc_load` pulse.

Operation codes on `op_code` are as follows:
- 0: no-operation
- 1: long jump
- 2: short jump
- 3: relative jump
- 4: long call
- 5: short call
- 6: software interrupt
- 7: return
- 8: return-and-skip
- 9: return-from-interrupt
- 10: push
- 11: pop
- 12 to 15: unassigned

Top module: `pcstk_seq`

## Requirements
- R1: While reset is held and after it is released, the outputs are `pc`=0, `sp`=0x2F (parameter SP_RESET), `gie`=0, `busy`=0, `mem_we`=0, `mem_re`=0 and `acc_load`=0.
- R2: A long jump (code 1) loads `pc` with `op_addr` at the accepting edge. No-operation (code 0) and the unassigned codes 12 to 15 advance `pc` by 1 modulo 2^15, so 0x7FFF advances to 0.
- R3: A short jump (code 2) or short call (code 5) forms its target from `op_addr[11:0]` as the low 12 bits. The upper 3 bits come from `pc`+1.
- R4: A relative jump (code 3) sets `pc` to `pc` plus the sign-extended 6-bit `op_disp`, modulo 2^15.
- R5: A push (code 10) writes `acc_in` to address `sp` in the cycle after acceptance. At the next edge, `sp` decreases by 1 and `pc` advances by 1.
- R6: A pop (code 11) reads address `sp`+1. Two edges later, `sp` increases by 1 and `pc` advances by 1. In the following cycle, `acc_out` holds the byte read and `acc_load` is high for one cycle.
- R7: A call (codes 4, 5) or software interrupt (code 6) writes the low byte of `pc`+1 to address `sp`. In the next cycle it writes the high byte to `sp`-1. It then lowers `sp` by 2 and loads the target. The software interrupt target is 0x0FF.
- R8: A return (codes 7, 8, 9) reads the low byte from `sp`+2, then the high byte from `sp`+1. It raises `sp` by 2 and loads `pc` from the two bytes. Return-and-skip adds 1 to that value. Return-from-interrupt also sets `gie` to 1.
- R9: `sp` and every stack address wrap modulo 256.
- R10: `op_start` is ignored while `busy` is high. The running operation completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_start | input | 1 | Present an operation this cycle |
| op_code | input | 4 | Operation code |
| op_addr | input | 15 | Long address; low 12 bits are the short field |
| op_disp | input | 6 | Signed relative displacement |
| acc_in | input | 8 | Accumulator value for a push |
| mem_rdata | input | 8 | Data memory read byte, one cycle after mem_re |
| pc | output | 15 | Program counter |
| sp | output | 8 | Stack pointer |
| busy | output | 1 | Stack sequence in progress |
| mem_we | output | 1 | Data memory write strobe |
| mem_re | output | 1 | Data memory read strobe |
| mem_addr | output | 8 | Data memory address |
| mem_wdata | output | 8 | Data memory write byte |
| gie | output | 1 | Global interrupt enable |
| acc_out | output | 8 | Byte returned by a pop |
| acc_load | output | 1 | acc_out is valid this cycle |

## Verification
The hardest situation to reach from the ports is the stack pointer crossing the 0x00/0xFF boundary while a two-byte call or return straddles it. In that case the two bytes of one return address sit at opposite ends of the memory. The stimulus reaches it by pushing enough bytes to walk `sp` down from its reset value to 0xFF, then popping once to land on 0x00. From there it performs a call and a return across the boundary. A second hard case is a new `op_start` held during a running push; the bench holds a jump request through the busy cycle and checks that it never lands.

// File: rtl/pcstk_pkg.sv
package pcstk_pkg;

  typedef enum logic [3:0] {
    OP_NOP   = 4'd0,
    OP_JMPL  = 4'd1,
    OP_JMP   = 4'd2,
    OP_JREL  = 4'd3,
    OP_CALLL = 4'd4,
    OP_CALL  = 4'd5,
    OP_SWI   = 4'd6,
    OP_RET   = 4'd7,
    OP_RETSK = 4'd8,
    OP_RETI  = 4'd9,
    OP_PUSH  = 4'd10,
    OP_POP   = 4'd11
  } op_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PUSH_W,
    ST_POP_R,
    ST_POP_D,
    ST_CALL_LO,
    ST_CALL_HI,
    ST_RET_LO,
    ST_RET_HI,
    ST_RET_FIN
  } stk_state_e;

endpackage

// File: rtl/pcstk_target.sv
module pcstk_target
  import pcstk_pkg::*;
#(
  parameter int PC_W    = 15,
  parameter int SHORT_W = 12,
  parameter int DISP_W  = 6,
  parameter logic [PC_W-1:0] SWI_VEC = 'h0FF
) (
  input  logic [3:0]        op,
  input  logic [PC_W-1:0]   pc,
  input  logic [PC_W-1:0]   addr,
  input  logic [DISP_W-1:0] disp,
  output logic [PC_W-1:0]   pc_seq,
  output logic [PC_W-1:0]   tgt,
  output logic              multi
);

  localparam int EXT_W = PC_W - DISP_W;

  function automatic logic [PC_W-1:0] f_rel(input logic [PC_W-1:0] base,
                                            input logic [DISP_W-1:0] d);
    f_rel = base + {{EXT_W{d[DISP_W-1]}}, d};
  endfunction

  function automatic logic [PC_W-1:0] f_short(input logic [PC_W-1:0] base,
                                              input logic [SHORT_W-1:0] field);
    f_short = {base[PC_W-1:SHORT_W], field};
  endfunction

  assign pc_seq = pc + PC_W'(1);

  always_comb begin
    case (op)
      OP_JMPL, OP_CALLL: tgt = addr;
      OP_JMP,  OP_CALL:  tgt = f_short(pc_seq, addr[SHORT_W-1:0]);
      OP_JREL:           tgt = f_rel(pc, disp);
      OP_SWI:            tgt = SWI_VEC;
      default:           tgt = pc_seq;
    endcase
  end

  always_comb begin
    case (op)
      OP_CALLL, OP_CALL, OP_SWI, OP_RET, OP_RETSK, OP_RETI,
      OP_PUSH, OP_POP: multi = 1'b1;
      default:         multi = 1'b0;
    endcase
  end

endmodule

// File: rtl/pcstk_stack.sv
module pcstk_stack
  import pcstk_pkg::*;
#(
  parameter int PC_W = 15,
  parameter int SP_W = 8,
  parameter logic [SP_W-1:0] SP_RESET = 'h2F
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [3:0]      op,
  input  logic [7:0]      acc_in,
  input  logic [PC_W-1:0] ret_pc,
  input  logic [7:0]      mem_rdata,
  output logic [SP_W-1:0] sp,
  output logic            busy,
  output logic            mem_we,
  output logic            mem_re,
  output logic [SP_W-1:0] mem_addr,
  output logic [7:0]      mem_wdata,
  output logic            commit,
  output logic [3:0]      commit_op,
  output logic            call_lo,
  output logic [PC_W-1:0] restored,
  output logic [7:0]      acc_out,
  output logic            acc_load
);

  localparam int HI_W  = PC_W - 8;
  localparam int PAD_W = 8 - HI_W;

  stk_state_e        state;
  logic [3:0]        op_q;
  logic [7:0]        lo_q, hi_q, dat_q, pl_q;
  logic [SP_W-1:0]   sp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      op_q     <= 4'd0;
      lo_q     <= 8'd0;
      hi_q     <= 8'd0;
      dat_q    <= 8'd0;
      pl_q     <= 8'd0;
      sp_q     <= SP_RESET;
      acc_out  <= 8'd0;
      acc_load <= 1'b0;
    end else begin
      acc_load <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          op_q  <= op;
          lo_q  <= ret_pc[7:0];
          hi_q  <= {{PAD_W{1'b0}}, ret_pc[PC_W-1:8]};
          dat_q <= acc_in;
          case (op)
            OP_PUSH:                   state <= ST_PUSH_W;
            OP_POP:                    state <= ST_POP_R;
            OP_CALLL, OP_CALL, OP_SWI: state <= ST_CALL_LO;
            OP_RET, OP_RETSK, OP_RETI: state <= ST_RET_LO;
            default:                   state <= ST_IDLE;
          endcase
        end
        ST_PUSH_W: begin
          sp_q  <= sp_q - SP_W'(1);
          state <= ST_IDLE;
        end
        ST_POP_R: state <= ST_POP_D;
        ST_POP_D: begin
          sp_q     <= sp_q + SP_W'(1);
          acc_out  <= mem_rdata;
          acc_load <= 1'b1;
          state    <= ST_IDLE;
        end
        ST_CALL_LO: state <= ST_CALL_HI;
        ST_CALL_HI: begin
          sp_q  <= sp_q - SP_W'(2);
          state <= ST_IDLE;
        end
        ST_RET_LO: state <= ST_RET_HI;
        ST_RET_HI: begin
          pl_q  <= mem_rdata;
          state <= ST_RET_FIN;
        end
        ST_RET_FIN: begin
          sp_q  <= sp_q + SP_W'(2);
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_we    = 1'b0;
    mem_re    = 1'b0;
    mem_addr  = sp_q;
    mem_wdata = 8'd0;
    case (state)
      ST_PUSH_W: begin
        mem_we    = 1'b1;
        mem_wdata = dat_q;
      end
      ST_POP_R: begin
        mem_re   = 1'b1;
        mem_addr = sp_q + SP_W'(1);
      end
      ST_CALL_LO: begin
        mem_we    = 1'b1;
        mem_wdata = lo_q;
      end
      ST_CALL_HI: begin
        mem_we    = 1'b1;
        mem_addr  = sp_q - SP_W'(1);
        mem_wdata = hi_q;
      end
      ST_RET_LO: begin
        mem_re   = 1'b1;
        mem_addr = sp_q + SP_W'(2);
      end
      ST_RET_HI: begin
        mem_re   = 1'b1;
        mem_addr = sp_q + SP_W'(1);
      end
      default: ;
    endcase
  end

  assign commit    = (state == ST_PUSH_W) || (state == ST_POP_D) ||
                     (state == ST_CALL_HI) || (state == ST_RET_FIN);
  assign commit_op = op_q;
  assign call_lo   = (state == ST_CALL_LO);
  assign restored  = {mem_rdata[HI_W-1:0], pl_q};
  assign busy      = (state != ST_IDLE);
  assign sp        = sp_q;

endmodule

// File: rtl/pcstk_seq.sv
module pcstk_seq
  import pcstk_pkg::*;
#(
  parameter int PC_W    = 15,
  parameter int SHORT_W = 12,
  parameter int DISP_W  = 6,
  parameter int SP_W    = 8,
  parameter logic [SP_W-1:0] SP_RESET = 'h2F,
  parameter logic [PC_W-1:0] SWI_VEC  = 'h0FF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_start,
  input  logic [3:0]        op_code,
  input  logic [PC_W-1:0]   op_addr,
  input  logic [DISP_W-1:0] op_disp,
  input  logic [7:0]        acc_in,
  input  logic [7:0]        mem_rdata,
  output logic [PC_W-1:0]   pc,
  output logic [SP_W-1:0]   sp,
  output logic              busy,
  output logic              mem_we,
  output logic              mem_re,
  output logic [SP_W-1:0]   mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              gie,
  output logic [7:0]        acc_out,
  output logic              acc_load
);

  logic [PC_W-1:0] pc_q, pc_seq, tgt, tgt_q, restored;
  logic            multi, accept, commit_w, call_lo_w, reti_commit_w, gie_q;
  logic [3:0]      cop;

  assign accept = op_start && !busy;

  pcstk_target #(
    .PC_W(PC_W), .SHORT_W(SHORT_W), .DISP_W(DISP_W), .SWI_VEC(SWI_VEC)
  ) u_tgt (
    .op(op_code), .pc(pc_q), .addr(op_addr), .disp(op_disp),
    .pc_seq(pc_seq), .tgt(tgt), .multi(multi)
  );

  pcstk_stack #(
    .PC_W(PC_W), .SP_W(SP_W), .SP_RESET(SP_RESET)
  ) u_stk (
    .clk(clk), .rst_n(rst_n), .start(accept), .op(op_code), .acc_in(acc_in),
    .ret_pc(pc_seq), .mem_rdata(mem_rdata), .sp(sp), .busy(busy),
    .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .commit(commit_w), .commit_op(cop),
    .call_lo(call_lo_w), .restored(restored), .acc_out(acc_out),
    .acc_load(acc_load)
  );

  assign reti_commit_w = commit_w && (cop == OP_RETI);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q  <= '0;
      tgt_q <= '0;
      gie_q <= 1'b0;
    end else begin
      if (accept) tgt_q <= tgt;
      if (accept && !multi) begin
        pc_q <= tgt;
      end else if (commit_w) begin
        case (cop)
          OP_CALLL, OP_CALL, OP_SWI: pc_q <= tgt_q;
          OP_RET, OP_RETI:           pc_q <= restored;
          OP_RETSK:                  pc_q <= restored + PC_W'(1);
          default:                   pc_q <= pc_seq;
        endcase
      end
      if (reti_commit_w) gie_q <= 1'b1;
    end
  end

  assign pc  = pc_q;
  assign gie = gie_q;

endmodule

// File: rtl/pcstk_seq_chk.sv
module pcstk_seq_chk #(
  parameter int SP_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            mem_we,
  input logic            mem_re,
  input logic [SP_W-1:0] mem_addr,
  input logic [SP_W-1:0] sp,
  input logic            gie,
  input logic            acc_load,
  input logic            commit_w,
  input logic            call_lo_w,
  input logic            reti_commit_w
);

  // R1
  strobe_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_re) |-> (busy && !(mem_we && mem_re)));

  // R9
  sp_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_w |=> $stable(sp));

  // R7
  call_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    call_lo_w |=> (mem_we && mem_addr == $past(mem_addr) - SP_W'(1)));

  // R6
  pop_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_load |-> $past(mem_re, 2));

  // R8
  gie_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gie) |-> $past(reti_commit_w));

endmodule

bind pcstk_seq pcstk_seq_chk #(.SP_W(SP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .mem_we(mem_we), .mem_re(mem_re),
  .mem_addr(mem_addr), .sp(sp), .gie(gie), .acc_load(acc_load),
  .commit_w(commit_w), .call_lo_w(call_lo_w), .reti_commit_w(reti_commit_w)
);

// File: tb/pcstk_seq_tb.sv
module pcstk_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 150000;
  localparam int NV         = 14;

  typedef struct packed {
    logic [3:0]  op;
    logic [14:0] addr;
    logic [5:0]  disp;
    logic [7:0]  acc;
    logic [14:0] pc;
    logic [7:0]  sp;
    logic        gie;
  } vec_t;

  localparam vec_t TBL [NV] = '{
    '{4'd1,  15'h1234, 6'd0,  8'h00, 15'h1234, 8'h2F, 1'b0}, // R2 long jump
    '{4'd3,  15'h0000, 6'd5,  8'h00, 15'h1239, 8'h2F, 1'b0}, // R4 forward
    '{4'd3,  15'h0000, 6'h38, 8'h00, 15'h1231, 8'h2F, 1'b0}, // R4 back -8
    '{4'd2,  15'h0ABC, 6'd0,  8'h00, 15'h1ABC, 8'h2F, 1'b0}, // R3 short jump
    '{4'd10, 15'h0000, 6'd0,  8'h5A, 15'h1ABD, 8'h2E, 1'b0}, // R5 push
    '{4'd4,  15'h0400, 6'd0,  8'h00, 15'h0400, 8'h2C, 1'b0}, // R7 long call
    '{4'd5,  15'h0123, 6'd0,  8'h00, 15'h0123, 8'h2A, 1'b0}, // R3 short call
    '{4'd6,  15'h0000, 6'd0,  8'h00, 15'h00FF, 8'h28, 1'b0}, // R7 soft int
    '{4'd9,  15'h0000, 6'd0,  8'h00, 15'h0124, 8'h2A, 1'b1}, // R8 reti
    '{4'd8,  15'h0000, 6'd0,  8'h00, 15'h0402, 8'h2C, 1'b1}, // R8 skip
    '{4'd7,  15'h0000, 6'd0,  8'h00, 15'h1ABE, 8'h2E, 1'b1}, // R8 return
    '{4'd11, 15'h0000, 6'd0,  8'h5A, 15'h1ABF, 8'h2F, 1'b1}, // R6 pop
    '{4'd0,  15'h0000, 6'd0,  8'h00, 15'h1AC0, 8'h2F, 1'b1}, // R2 nop
    '{4'd15, 15'h0000, 6'd0,  8'h00, 15'h1AC1, 8'h2F, 1'b1}  // R2 unassigned
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_start = 1'b0;
  logic [3:0]  op_code = 4'd0;
  logic [14:0] op_addr = '0;
  logic [5:0]  op_disp = '0;
  logic [7:0]  acc_in = '0;
  logic [7:0]  mem_rdata = '0;
  logic [14:0] pc;
  logic [7:0]  sp;
  logic        busy, mem_we, mem_re, gie, acc_load;
  logic [7:0]  mem_addr, mem_wdata, acc_out;
  logic [7:0]  mem [256];

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    if (mem_re) mem_rdata <= mem[mem_addr];
  end

  pcstk_seq u_dut (
    .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_code(op_code),
    .op_addr(op_addr), .op_disp(op_disp), .acc_in(acc_in),
    .mem_rdata(mem_rdata), .pc(pc), .sp(sp), .busy(busy), .mem_we(mem_we),
    .mem_re(mem_re), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .gie(gie),
    .acc_out(acc_out), .acc_load(acc_load)
  );

  task automatic chk(input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [3:0] op, input logic [14:0] a,
                        input logic [5:0] d, input logic [7:0] acc);
    @(negedge clk);
    op_code = op; op_addr = a; op_disp = d; acc_in = acc; op_start = 1'b1;
    @(negedge clk);
    op_start = 1'b0;
    for (int k = 0; k < 20 && busy; k++) @(negedge clk);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R1 reset state, while held and after release
    chk("R1 pc in reset", 32'(pc), 32'h0);
    chk("R1 sp in reset", 32'(sp), 32'h2F);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pc", 32'(pc), 32'h0);
    chk("R1 sp", 32'(sp), 32'h2F);
    chk("R1 gie", 32'(gie), 32'h0);
    chk("R1 busy", 32'(busy), 32'h0);
    chk("R1 strobes", 32'({mem_we, mem_re, acc_load}), 32'h0);

    for (int v = 0; v < NV; v++) begin
      run_op(TBL[v].op, TBL[v].addr, TBL[v].disp, TBL[v].acc);
      chk($sformatf("vec%0d pc", v), 32'(pc), 32'(TBL[v].pc));
      chk($sformatf("vec%0d sp", v), 32'(sp), 32'(TBL[v].sp));
      chk($sformatf("vec%0d gie", v), 32'(gie), 32'(TBL[v].gie));
      chk($sformatf("vec%0d busy", v), 32'(busy), 32'h0);
      if (TBL[v].op == 4'd11) begin
        chk("R6 acc_out", 32'(acc_out), 32'(TBL[v].acc));
        chk("R6 acc_load", 32'(acc_load), 32'h1);
        @(negedge clk);
        chk("R6 acc_load single", 32'(acc_load), 32'h0);
      end
    end

    // R5 pushed byte, R7 byte order of pushed return addresses
    chk("R5 mem[2F]", 32'(mem[8'h2F]), 32'h5A);
    chk("R7 low byte at sp", 32'(mem[8'h2E]), 32'hBE);
    chk("R7 high byte at sp-1", 32'(mem[8'h2D]), 32'h1A);
    chk("R7 swi low", 32'(mem[8'h2A]), 32'h24);
    chk("R7 swi high", 32'(mem[8'h29]), 32'h01);

    // R10 start held during a running push is ignored
    @(negedge clk);
    op_code = 4'd10; acc_in = 8'h77; op_start = 1'b1;
    @(negedge clk);
    op_code = 4'd1; op_addr = 15'h0555;
    @(negedge clk);
    op_start = 1'b0;
    chk("R10 pc", 32'(pc), 32'h1AC2);
    chk("R10 sp", 32'(sp), 32'h2E);
    chk("R10 pushed", 32'(mem[8'h2F]), 32'h77);
    @(negedge clk);
    chk("R10 no late jump", 32'(pc), 32'h1AC2);

    // R4 relative wrap below zero, R2 wrap at the top
    run_op(4'd1, 15'h0002, 6'd0, 8'h00);
    run_op(4'd3, 15'h0000, 6'h3C, 8'h00);
    chk("R4 wrap", 32'(pc), 32'h7FFE);
    run_op(4'd0, 15'h0000, 6'd0, 8'h00);
    run_op(4'd0, 15'h0000, 6'd0, 8'h00);
    chk("R2 wrap", 32'(pc), 32'h0000);

    // R9 walk sp down through zero
    for (int i = 0; i < 47; i++) run_op(4'd10, 15'h0, 6'd0, 8'(i));
    chk("R9 sp after pushes", 32'(sp), 32'hFF);
    run_op(4'd11, 15'h0, 6'd0, 8'h00);
    chk("R9 sp pop wrap", 32'(sp), 32'h00);
    chk("R9 popped byte", 32'(acc_out), 32'h2E);
    chk("R9 pc", 32'(pc), 32'h0030);
    run_op(4'd4, 15'h0100, 6'd0, 8'h00);
    chk("R9 call sp", 32'(sp), 32'hFE);
    chk("R9 call low at 00", 32'(mem[8'h00]), 32'h31);
    chk("R9 call high at FF", 32'(mem[8'hFF]), 32'h00);
    chk("R9 call pc", 32'(pc), 32'h0100);
    run_op(4'd7, 15'h0, 6'd0, 8'h00);
    chk("R9 ret sp", 32'(sp), 32'h00);
    chk("R9 ret pc", 32'(pc), 32'h0031);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule